// File: doc/BRIEF.md
# Clock Output Crosspoint and Post-Dividers

This block takes four frequency sources and turns them into five divided clock outputs and one buffered reference. The sources are the reference, PLL1, PLL2 and PLL3. Each arrives as a one-cycle enable pulse on a single fast master clock. Each output is a registered level that changes only in the cycle after an edge of its source. It is therefore a clock-enable-style waveform in the master domain.

Outputs A to D each pick any of the four sources through a crosspoint and divide it with a 7-bit post-divider. Outputs A and B each hold two divide values. One shared bank select picks which of the two both of them use. Output E always divides PLL1 by 2, 3 or 4 and ignores the crosspoint. Any change of divide value, bank or source is held pending and applied only where the output rises. A change therefore never cuts or stretches a phase in progress.

Top module: `clkout_xbar`

## Requirements
- R1: The source select of outputs A to D encodes 0 as the reference, 1 as PLL1, 2 as PLL2 and 3 as PLL3. Any output may select any source.
- R2: With a divide value N of 2 or more, the output period is N source pulses. The high phase is ceil(N/2) pulses and the low phase is floor(N/2) pulses. The output changes in the master cycle after the source pulse that ends a phase.
- R3: With a divide value of 1, the output is high exactly in the cycle after each pulse of its source and low otherwise.
- R4: A divide value of 0 holds the output low once the period in progress has ended.
- R5: Outputs A and B use their set-0 values while bank_sel_i is 0 and their set-1 values while it is 1.
- R6: Output E divides PLL1 pulses by the code e_code_i: 00 gives /2, 01 gives /3, 10 gives /4 and 11 gives /4. No phase of E lasts more than 2 PLL1 pulses. E changes only after a PLL1 pulse.
- R7: A new divide value or bank selection takes effect at the next rising edge of the output. The period in progress completes with the old value.
- R8: A new source select takes effect at the next rising edge of the output. The divider then counts pulses of the new source from zero.
- R9: ref_buf_o equals the reference pulse input delayed by one master cycle.
- R10: While reset is held, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick_i | input | 4 | Source pulses: bit 0 reference, 1 PLL1, 2 PLL2, 3 PLL3 |
| xsel_a_i | input | 2 | Source select for output A |
| xsel_b_i | input | 2 | Source select for output B |
| xsel_c_i | input | 2 | Source select for output C |
| xsel_d_i | input | 2 | Source select for output D |
| div_a0_i | input | 7 | Output A divide value, set 0 |
| div_a1_i | input | 7 | Output A divide value, set 1 |
| div_b0_i | input | 7 | Output B divide value, set 0 |
| div_b1_i | input | 7 | Output B divide value, set 1 |
| div_c_i | input | 7 | Output C divide value |
| div_d_i | input | 7 | Output D divide value |
| bank_sel_i | input | 1 | Shared set select for outputs A and B |
| e_code_i | input | 2 | Output E divide code |
| clk_a_o | output | 1 | Divided output A |
| clk_b_o | output | 1 | Divided output B |
| clk_c_o | output | 1 | Divided output C |
| clk_d_o | output | 1 | Divided output D |
| clk_e_o | output | 1 | PLL1 divided by 2, 3 or 4 |
| ref_buf_o | output | 1 | Buffered reference |

## Verification
The bench goes after changes made in the middle of a period. It flips the bank select and moves the crosspoint just after a rising edge, then measures the phase in progress in source pulses. A design that applied the change at once would cut that phase short or count it on the wrong source. Odd divide values and the reserved E code are measured on their own, since an off-by-one in the high-phase length or a wrong decode would show up as a skewed period. A divide value of 1 and the disable value 0 are checked cycle by cycle. A design that kept counting, or left the output stuck high, would fail those checks.

// File: rtl/ckx_pkg.sv
package ckx_pkg;
  localparam int unsigned SRC_REF  = 0;
  localparam int unsigned SRC_PLL1 = 1;
  localparam int unsigned SRC_PLL2 = 2;
  localparam int unsigned SRC_PLL3 = 3;

  // Output E divide code: 0 -> 2, 1 -> 3, 2 and 3 -> 4
  function automatic logic [2:0] e_ratio(input logic [1:0] code);
    case (code)
      2'b00:   e_ratio = 3'd2;
      2'b01:   e_ratio = 3'd3;
      default: e_ratio = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/ckx_divcore.sv
module ckx_divcore #(
  parameter int DW = 7,
  parameter int NS = 4,
  localparam int SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] tick_i,
  input  logic [SW-1:0] req_sel_i,
  input  logic [DW-1:0] req_n_i,
  output logic          out_o
);
  localparam logic [DW:0]   ONE_W = 1;
  localparam logic [DW-1:0] ONE_N = 1;

  logic [DW-1:0] cur_n, cnt;
  logic [SW-1:0] cur_sel;
  logic          out_q;
  logic          t, at_end;
  logic [DW:0]   hi_len, nxt_cnt;

  always_comb begin
    t       = tick_i[cur_sel];
    at_end  = (cnt >= cur_n - ONE_N);
    hi_len  = ({1'b0, cur_n} + ONE_W) >> 1;
    nxt_cnt = {1'b0, cnt} + ONE_W;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_n   <= '0;
      cur_sel <= '0;
      cnt     <= '1;
      out_q   <= 1'b0;
    end else if (cur_n == '0) begin
      // disabled: take the request at once, primed to rise on first pulse
      out_q   <= 1'b0;
      cnt     <= '1;
      cur_n   <= req_n_i;
      cur_sel <= req_sel_i;
    end else if (cur_n == ONE_N) begin
      out_q <= t && (req_n_i != '0);
      if (t) begin
        cnt     <= '0;
        cur_n   <= req_n_i;
        cur_sel <= req_sel_i;
      end
    end else if (t) begin
      if (at_end) begin
        // rising boundary: pending settings are applied here
        cnt     <= '0;
        out_q   <= (req_n_i != '0);
        cur_n   <= req_n_i;
        cur_sel <= req_sel_i;
      end else begin
        cnt   <= nxt_cnt[DW-1:0];
        out_q <= (nxt_cnt < hi_len);
      end
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/ckx_setpick.sv
module ckx_setpick #(
  parameter int DW = 7
) (
  input  logic          bank_sel_i,
  input  logic [DW-1:0] a0_i,
  input  logic [DW-1:0] a1_i,
  input  logic [DW-1:0] b0_i,
  input  logic [DW-1:0] b1_i,
  input  logic [1:0]    e_code_i,
  output logic [DW-1:0] n_a_o,
  output logic [DW-1:0] n_b_o,
  output logic [DW-1:0] n_e_o
);
  always_comb begin
    n_a_o = bank_sel_i ? a1_i : a0_i;
    n_b_o = bank_sel_i ? b1_i : b0_i;
    n_e_o = DW'(ckx_pkg::e_ratio(e_code_i));
  end
endmodule

// File: rtl/ckx_refbuf.sv
module ckx_refbuf (
  input  logic clk,
  input  logic rst,
  input  logic ref_tick_i,
  output logic ref_o
);
  always_ff @(posedge clk) begin
    if (rst) ref_o <= 1'b0;
    else     ref_o <= ref_tick_i;
  end
endmodule

// File: rtl/clkout_xbar.sv
module clkout_xbar #(
  parameter int DW = 7,
  parameter int NS = 4,
  localparam int SW = $clog2(NS),
  localparam int NL = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] src_tick_i,
  input  logic [SW-1:0] xsel_a_i,
  input  logic [SW-1:0] xsel_b_i,
  input  logic [SW-1:0] xsel_c_i,
  input  logic [SW-1:0] xsel_d_i,
  input  logic [DW-1:0] div_a0_i,
  input  logic [DW-1:0] div_a1_i,
  input  logic [DW-1:0] div_b0_i,
  input  logic [DW-1:0] div_b1_i,
  input  logic [DW-1:0] div_c_i,
  input  logic [DW-1:0] div_d_i,
  input  logic          bank_sel_i,
  input  logic [1:0]    e_code_i,
  output logic          clk_a_o,
  output logic          clk_b_o,
  output logic          clk_c_o,
  output logic          clk_d_o,
  output logic          clk_e_o,
  output logic          ref_buf_o
);
  logic [DW-1:0] n_a, n_b, n_e;
  logic [DW-1:0] lane_n   [NL];
  logic [SW-1:0] lane_sel [NL];
  logic [NL-1:0] lane_out;

  ckx_setpick #(.DW(DW)) u_pick (
    .bank_sel_i (bank_sel_i),
    .a0_i       (div_a0_i),
    .a1_i       (div_a1_i),
    .b0_i       (div_b0_i),
    .b1_i       (div_b1_i),
    .e_code_i   (e_code_i),
    .n_a_o      (n_a),
    .n_b_o      (n_b),
    .n_e_o      (n_e)
  );

  always_comb begin
    lane_n[0] = n_a;      lane_sel[0] = xsel_a_i;
    lane_n[1] = n_b;      lane_sel[1] = xsel_b_i;
    lane_n[2] = div_c_i;  lane_sel[2] = xsel_c_i;
    lane_n[3] = div_d_i;  lane_sel[3] = xsel_d_i;
  end

  for (genvar i = 0; i < NL; i++) begin : g_lane
    ckx_divcore #(.DW(DW), .NS(NS)) u_div (
      .clk       (clk),
      .rst       (rst),
      .tick_i    (src_tick_i),
      .req_sel_i (lane_sel[i]),
      .req_n_i   (lane_n[i]),
      .out_o     (lane_out[i])
    );
  end

  ckx_divcore #(.DW(DW), .NS(NS)) u_div_e (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (src_tick_i),
    .req_sel_i (SW'(ckx_pkg::SRC_PLL1)),
    .req_n_i   (n_e),
    .out_o     (clk_e_o)
  );

  ckx_refbuf u_ref (
    .clk        (clk),
    .rst        (rst),
    .ref_tick_i (src_tick_i[ckx_pkg::SRC_REF]),
    .ref_o      (ref_buf_o)
  );

  assign clk_a_o = lane_out[0];
  assign clk_b_o = lane_out[1];
  assign clk_c_o = lane_out[2];
  assign clk_d_o = lane_out[3];
endmodule

// File: rtl/ckx_chk.sv
module ckx_chk #(
  parameter int NS = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [NS-1:0] src_tick_i,
  input logic          clk_a_o,
  input logic          clk_c_o,
  input logic          clk_e_o,
  input logic          ref_buf_o
);
  logic       warm;
  logic       e_prev;
  logic [2:0] e_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      warm   <= 1'b0;
      e_prev <= 1'b0;
      e_run  <= '0;
    end else begin
      warm   <= 1'b1;
      e_prev <= clk_e_o;
      if (clk_e_o != e_prev) e_run <= {2'b00, src_tick_i[1]};
      else                   e_run <= e_run + {2'b00, src_tick_i[1]};
    end
  end

  // R9
  a_r9_refbuf_follows: assert property (@(posedge clk) disable iff (rst || !warm)
    ref_buf_o == $past(src_tick_i[0]));

  // R6
  a_r6_e_moves_on_pll1: assert property (@(posedge clk) disable iff (rst || !warm)
    !$stable(clk_e_o) |-> $past(src_tick_i[1]));

  // R6
  a_r6_e_phase_bound: assert property (@(posedge clk) disable iff (rst || !warm)
    e_run <= 3'd2);

  // R2
  a_r2_a_rise_on_tick: assert property (@(posedge clk) disable iff (rst || !warm)
    $rose(clk_a_o) |-> $past(|src_tick_i));

  // R2
  a_r2_c_rise_on_tick: assert property (@(posedge clk) disable iff (rst || !warm)
    $rose(clk_c_o) |-> $past(|src_tick_i));

  // R10
  a_r10_reset_low: assert property (@(posedge clk)
    $past(rst) |-> !clk_e_o && !ref_buf_o);
endmodule

bind clkout_xbar ckx_chk #(.NS(NS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .src_tick_i (src_tick_i),
  .clk_a_o    (clk_a_o),
  .clk_c_o    (clk_c_o),
  .clk_e_o    (clk_e_o),
  .ref_buf_o  (ref_buf_o)
);

// File: tb/test_clkout_xbar.sv
module test_clkout_xbar;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] src_tick;
  logic [1:0] xsel_a, xsel_b, xsel_c, xsel_d;
  logic [6:0] div_a0, div_a1, div_b0, div_b1, div_c, div_d;
  logic       bank_sel;
  logic [1:0] e_code;
  logic       clk_a, clk_b, clk_c, clk_d, clk_e, ref_buf;

  int per [4];
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  clkout_xbar i_clkout_xbar (
    .clk(clk), .rst(rst), .src_tick_i(src_tick),
    .xsel_a_i(xsel_a), .xsel_b_i(xsel_b), .xsel_c_i(xsel_c), .xsel_d_i(xsel_d),
    .div_a0_i(div_a0), .div_a1_i(div_a1), .div_b0_i(div_b0), .div_b1_i(div_b1),
    .div_c_i(div_c), .div_d_i(div_d), .bank_sel_i(bank_sel), .e_code_i(e_code),
    .clk_a_o(clk_a), .clk_b_o(clk_b), .clk_c_o(clk_c), .clk_d_o(clk_d),
    .clk_e_o(clk_e), .ref_buf_o(ref_buf)
  );

  // source pulse generator, driven away from the active edge
  initial begin
    int k [4];
    src_tick = '0;
    for (int i = 0; i < 4; i++) begin k[i] = 0; per[i] = 0; end
    forever begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        if (per[i] == 0) begin
          k[i] = 0; src_tick[i] = 1'b0;
        end else begin
          k[i] = k[i] + 1;
          if (k[i] >= per[i]) begin k[i] = 0; src_tick[i] = 1'b1; end
          else src_tick[i] = 1'b0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  function automatic logic lane_out(input int lane);
    case (lane)
      0: return clk_a;
      1: return clk_b;
      2: return clk_c;
      3: return clk_d;
      default: return clk_e;
    endcase
  endfunction

  task automatic wait_rise(input int lane, output bit ok);
    logic prev = lane_out(lane);
    ok = 1'b0;
    for (int i = 0; i < 500; i++) begin
      step();
      if (!prev && lane_out(lane)) begin ok = 1'b1; return; end
      prev = lane_out(lane);
    end
  endtask

  // starts at a rising sample, ends at the next rising sample
  task automatic run_period(input int lane, input int src, output int hi, output int lo);
    bit ph = 1'b1;
    hi = 0; lo = 0;
    for (int i = 0; i < 500; i++) begin
      step();
      if (src_tick[src]) begin if (ph) hi++; else lo++; end
      if (ph && !lane_out(lane)) ph = 1'b0;
      else if (!ph && lane_out(lane)) return;
    end
    hi = -1; lo = -1;
  endtask

  task automatic measure(input int lane, input int src, input int eh, input int el,
                         input string req);
    bit ok;
    int hi, lo;
    wait_rise(lane, ok);
    check(ok, req, int'(ok), 1);
    run_period(lane, src, hi, lo);
    run_period(lane, src, hi, lo);
    check(hi == eh, {req, " high"}, hi, eh);
    check(lo == el, {req, " low"}, lo, el);
  endtask

  task automatic t_reset();
    // R10: outputs low under reset
    rst = 1'b1;
    repeat (4) step();
    check({clk_a, clk_b, clk_c, clk_d, clk_e, ref_buf} == 6'b0, "R10",
          int'({clk_a, clk_b, clk_c, clk_d, clk_e, ref_buf}), 0);
    rst = 1'b0;
    step();
    check({clk_a, clk_b, clk_c, clk_d, clk_e, ref_buf} == 6'b0, "R10 after release",
          int'({clk_a, clk_b, clk_c, clk_d, clk_e, ref_buf}), 0);
    per[0] = 3; per[1] = 2; per[2] = 5; per[3] = 1;
  endtask

  task automatic t_routing();
    // R1 and R2: every lane on a different source, odd and even divides
    bank_sel = 1'b0;
    xsel_a = 2'd1; div_a0 = 7'd7;
    xsel_b = 2'd0; div_b0 = 7'd2;
    xsel_c = 2'd2; div_c  = 7'd5;
    xsel_d = 2'd3; div_d  = 7'd6;
    measure(0, 1, 4, 3, "R1 R2 A on PLL1 /7");
    measure(1, 0, 1, 1, "R1 R2 B on ref /2");
    measure(2, 2, 3, 2, "R1 R2 C on PLL2 /5");
    measure(3, 3, 3, 3, "R1 R2 D on PLL3 /6");
    div_c = 7'd4;
    measure(2, 2, 2, 2, "R2 C on PLL2 /4");
  endtask

  task automatic t_bypass();
    // R3: divide by 1 follows the source pulse
    int bad = 0;
    xsel_d = 2'd0; div_d = 7'd1;
    repeat (30) step();
    for (int i = 0; i < 40; i++) begin
      step();
      if (clk_d != src_tick[0]) bad++;
    end
    check(bad == 0, "R3 pass-through", bad, 0);
  endtask

  task automatic t_disable();
    // R4: zero divide holds the output low
    int highs = 0;
    xsel_c = 2'd0; div_c = 7'd3;
    repeat (30) step();
    div_c = 7'd0;
    repeat (20) step();
    for (int i = 0; i < 40; i++) begin
      step();
      if (clk_c) highs++;
    end
    check(highs == 0, "R4 disabled low", highs, 0);
  endtask

  task automatic t_bank();
    // R5: shared bank select for A and B
    xsel_a = 2'd1; xsel_b = 2'd1;
    div_a0 = 7'd4; div_a1 = 7'd6; div_b0 = 7'd2; div_b1 = 7'd8;
    bank_sel = 1'b0;
    measure(0, 1, 2, 2, "R5 A set 0");
    measure(1, 1, 1, 1, "R5 B set 0");
    bank_sel = 1'b1;
    measure(0, 1, 3, 3, "R5 A set 1");
    measure(1, 1, 4, 4, "R5 B set 1");
  endtask

  task automatic t_e();
    // R6: E code decode including reserved code
    e_code = 2'b00; measure(4, 1, 1, 1, "R6 code 00");
    e_code = 2'b01; measure(4, 1, 2, 1, "R6 code 01");
    e_code = 2'b10; measure(4, 1, 2, 2, "R6 code 10");
    e_code = 2'b11; measure(4, 1, 2, 2, "R6 code 11");
  endtask

  task automatic t_pending();
    // R7: bank change mid-period completes with the old value
    bit ok;
    int hi, lo;
    xsel_a = 2'd3; div_a0 = 7'd8; div_a1 = 7'd2; bank_sel = 1'b0;
    wait_rise(0, ok);
    run_period(0, 3, hi, lo);
    bank_sel = 1'b1;
    run_period(0, 3, hi, lo);
    check(hi == 4 && lo == 4, "R7 old period kept", hi * 10 + lo, 44);
    run_period(0, 3, hi, lo);
    check(hi == 1 && lo == 1, "R7 new value next", hi * 10 + lo, 11);
  endtask

  task automatic t_xsel();
    // R8: source change applied at rising edge, counts restart
    bit ok;
    int hi, lo;
    xsel_c = 2'd3; div_c = 7'd4;
    wait_rise(2, ok);
    run_period(2, 3, hi, lo);
    xsel_c = 2'd2;
    run_period(2, 3, hi, lo);
    check(hi == 2 && lo == 2, "R8 old source kept", hi * 10 + lo, 22);
    run_period(2, 2, hi, lo);
    check(hi == 2 && lo == 2, "R8 new source", hi * 10 + lo, 22);
  endtask

  task automatic t_refbuf();
    // R9: buffered reference one cycle behind the pulse
    int bad = 0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (ref_buf != src_tick[0]) bad++;
    end
    check(bad == 0, "R9 reference copy", bad, 0);
  endtask

  initial begin
    rst = 1'b1;
    xsel_a = '0; xsel_b = '0; xsel_c = '0; xsel_d = '0;
    div_a0 = '0; div_a1 = '0; div_b0 = '0; div_b1 = '0; div_c = '0; div_d = '0;
    bank_sel = 1'b0; e_code = 2'b00;
    t_reset();
    t_routing();
    t_bypass();
    t_disable();
    t_bank();
    t_e();
    t_pending();
    t_xsel();
    t_refbuf();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule